// File: doc/BRIEF.md
# Glitchless Frequency Step Controller

This block holds, for each output channel of a clock synthesizer, the word that programs a fractional output divider. It moves that word by a programmable step when it is asked to. Commands from a register interface can load a word, set a channel's step size, or step any channel up or down in frequency. Two pulse inputs step channel 0 only, at the rate of a slow pin interface. All other channels can be stepped only by commands.

Every requested move is checked against a frequency window before it is taken. The highest frequency allowed is the VCO rate divided by 8, which is a divider word of `8 << FRAC_W`. The lowest frequency allowed is given as the largest divider word, `MAX_WORD`. A move that would leave the window is dropped and raises a sticky out-of-range flag for that channel.

An accepted word first goes into a pending target. It reaches the divider only when that channel's wrap strobe marks the end of an output cycle, so the divider never changes in the middle of a period. Because each step works on the pending target, a series of steps adds up to exactly the number of steps times the step size.

Top module: `fstep_ctrl`

## Requirements
- R1: After reset, every channel's divider word and pending target equal `RESET_WORD`, every step size is 1 and every out-of-range flag is 0.
- R2: When `cmd_valid_i` is high, `cmd_op_i` selects the action for channel `cmd_ch_i`: 0 loads `cmd_data_i` as the target, 1 sets the channel's step size to `cmd_data_i`, 2 raises the frequency and 3 lowers it. The new step size is used from the next request onwards.
- R3: Raising the frequency lowers the target by the step size, and lowering it raises the target by the step size. After n accepted steps from a word W with step s, the target is exactly W − n·s or W + n·s.
- R4: The divider word takes the pending target only in a cycle in which that channel's wrap strobe is high and a new target is pending. In every other cycle it holds its value.
- R5: A raise that would make the target smaller than `8 << FRAC_W` is not applied and sets that channel's flag. A result exactly equal to the limit is accepted.
- R6: A lower that would make the target larger than `MAX_WORD` is not applied and sets that channel's flag. A result exactly equal to `MAX_WORD` is accepted.
- R7: A flag stays set through any steps and idle cycles until a load to that channel is accepted, which clears it. A load whose value lies outside the window is not applied and sets the flag.
- R8: A `pin_up_i` pulse raises the frequency of channel 0 and a `pin_dn_i` pulse lowers it, each exactly like the matching command. The pins never affect any other channel.
- R9: If one channel receives both a raise and a lower request in the same cycle, from any mix of pins and a command, neither is applied and its flag and target are unchanged.
- R10: A load command to channel 0 takes priority over a pin step that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_ch_i | input | CH_W | Target channel of the command |
| cmd_op_i | input | 2 | Command code: 0 load, 1 set step, 2 raise, 3 lower |
| cmd_data_i | input | WORD_W | Word to load or step size to set |
| pin_up_i | input | 1 | Single-cycle raise pulse for channel 0 |
| pin_dn_i | input | 1 | Single-cycle lower pulse for channel 0 |
| wrap_i | input | NUM_CH | Per-channel divider output-cycle boundary strobe |
| div_word_o | output | NUM_CH*WORD_W | Active divider words, channel 0 in the low bits |
| oor_o | output | NUM_CH | Sticky per-channel out-of-range flags |

## Verification
The hardest cases to reach from the ports are the limit crossings: the walk has to land exactly on a limit for one step size and jump past it for another. The stimulus gets there by walking every channel from a mid-window word to each limit with several step sizes, some that divide the distance evenly and some that do not. During these walks the wrap strobe is held back on some cycles, so pending targets pile up behind the active word. Channel 0 is also driven with pin pulses and commands in the same cycle, both opposing and matching, to reach the conflict and priority cases.

// File: rtl/fstep_pkg.sv
package fstep_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_STEP = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } fs_op_e;

    typedef struct packed {
        logic load;
        logic set_step;
        logic up;
        logic dn;
    } ch_req_t;

    function automatic int unsigned min_div_word(input int unsigned frac_w);
        return 32'd8 << frac_w;
    endfunction

    function automatic logic in_window(input logic [63:0] v,
                                       input logic [63:0] lo,
                                       input logic [63:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/fstep_req_merge.sv
module fstep_req_merge #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                cmd_valid_i,
    input  logic [CH_W-1:0]                     cmd_ch_i,
    input  logic [1:0]                          cmd_op_i,
    input  logic                                pin_up_i,
    input  logic                                pin_dn_i,
    output fstep_pkg::ch_req_t [NUM_CH-1:0]     req_o
);
    import fstep_pkg::*;

    fs_op_e op;
    assign op = fs_op_e'(cmd_op_i);

    logic [NUM_CH-1:0] load_v;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_req
        logic hit;
        assign hit = cmd_valid_i && (cmd_ch_i == CH_W'(c));
        assign req_o[c].load     = hit && (op == OP_LOAD);
        assign req_o[c].set_step = hit && (op == OP_STEP);
        assign load_v[c]         = req_o[c].load;
        if (c == 0) begin : g_pins
            assign req_o[c].up = (hit && (op == OP_INC)) || pin_up_i;
            assign req_o[c].dn = (hit && (op == OP_DEC)) || pin_dn_i;
        end else begin : g_cmd_only
            assign req_o[c].up = hit && (op == OP_INC);
            assign req_o[c].dn = hit && (op == OP_DEC);

            // R8: without a command, only channel 0 may see a step request
            a_r8_pins_ch0_only: assert property (@(posedge clk) disable iff (rst)
                !cmd_valid_i |-> (!req_o[c].up && !req_o[c].dn));
        end
    end

    // R2: one command addresses at most one channel
    a_r2_single_load: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_v));

endmodule

// File: rtl/fstep_channel.sv
module fstep_channel #(
    parameter int WORD_W     = 12,
    parameter int MIN_WORD   = 128,
    parameter int MAX_WORD   = 2000,
    parameter int RESET_WORD = 400
) (
    input  logic               clk,
    input  logic               rst,
    input  fstep_pkg::ch_req_t req_i,
    input  logic [WORD_W-1:0]  data_i,
    input  logic               wrap_i,
    output logic [WORD_W-1:0]  word_o,
    output logic               oor_o
);
    import fstep_pkg::*;

    localparam logic [63:0] LO64 = 64'(MIN_WORD);
    localparam logic [63:0] HI64 = 64'(MAX_WORD);

    logic [WORD_W-1:0] cur_q, cur_d;
    logic [WORD_W-1:0] next_q, next_d;
    logic [WORD_W-1:0] step_q, step_d;
    logic              flag_q, flag_d;
    logic              pend_q, pend_d;
    logic              applied;
    logic [WORD_W:0]   cand;
    logic              move_ok;
    logic              load_ok;

    // one extra bit keeps a borrow or a carry, which always lands above the window
    assign cand = req_i.up ? ({1'b0, next_q} - {1'b0, step_q})
                           : ({1'b0, next_q} + {1'b0, step_q});
    assign move_ok = in_window(64'(cand), LO64, HI64);
    assign load_ok = in_window(64'(data_i), LO64, HI64);

    always_comb begin
        step_d  = step_q;
        next_d  = next_q;
        flag_d  = flag_q;
        applied = 1'b0;
        if (req_i.set_step) begin
            step_d = data_i;
        end
        if (req_i.load) begin
            if (load_ok) begin
                next_d  = data_i;
                flag_d  = 1'b0;
                applied = 1'b1;
            end else begin
                flag_d  = 1'b1;
            end
        end else if (req_i.up ^ req_i.dn) begin
            if (move_ok) begin
                next_d  = cand[WORD_W-1:0];
                applied = 1'b1;
            end else begin
                flag_d  = 1'b1;
            end
        end
        pend_d = (pend_q && !wrap_i) || applied;
        cur_d  = (pend_q && wrap_i) ? next_q : cur_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= WORD_W'(RESET_WORD);
            next_q <= WORD_W'(RESET_WORD);
            step_q <= WORD_W'(1);
            flag_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            cur_q  <= cur_d;
            next_q <= next_d;
            step_q <= step_d;
            flag_q <= flag_d;
            pend_q <= pend_d;
        end
    end

    assign word_o = cur_q;
    assign oor_o  = flag_q;

    // R4: no boundary strobe, no change of the active word
    a_r4_hold_between_wraps: assert property (@(posedge clk) disable iff (rst)
        !wrap_i |=> $stable(cur_q));

    // R4: at a boundary a pending target becomes active
    a_r4_take_at_wrap: assert property (@(posedge clk) disable iff (rst)
        (pend_q && wrap_i) |=> (cur_q == $past(next_q)));

    // R5: target never below the highest-frequency limit
    a_r5_above_min: assert property (@(posedge clk) disable iff (rst)
        next_q >= WORD_W'(MIN_WORD));

    // R6: target never above the lowest-frequency limit
    a_r6_below_max: assert property (@(posedge clk) disable iff (rst)
        next_q <= WORD_W'(MAX_WORD));

    // R3: a lone raise moves the target by exactly one step, or is refused with the flag set
    a_r3_exact_raise: assert property (@(posedge clk) disable iff (rst)
        (req_i.up && !req_i.dn && !req_i.load) |=>
            ((next_q == $past(next_q) - $past(step_q)) || ($stable(next_q) && flag_q)));

    // R7: the flag is sticky without a load
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !req_i.load) |=> flag_q);

    // R9: opposing requests leave target and flag untouched
    a_r9_conflict_ignored: assert property (@(posedge clk) disable iff (rst)
        (req_i.up && req_i.dn && !req_i.load) |=> ($stable(next_q) && $stable(flag_q)));

endmodule

// File: rtl/fstep_ctrl.sv
module fstep_ctrl #(
    parameter int NUM_CH     = 4,
    parameter int WORD_W     = 12,
    parameter int FRAC_W     = 4,
    parameter int MAX_WORD   = 2000,
    parameter int RESET_WORD = 400,
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_valid_i,
    input  logic [CH_W-1:0]          cmd_ch_i,
    input  logic [1:0]               cmd_op_i,
    input  logic [WORD_W-1:0]        cmd_data_i,
    input  logic                     pin_up_i,
    input  logic                     pin_dn_i,
    input  logic [NUM_CH-1:0]        wrap_i,
    output logic [NUM_CH*WORD_W-1:0] div_word_o,
    output logic [NUM_CH-1:0]        oor_o
);
    import fstep_pkg::*;

    localparam int MIN_WORD = int'(min_div_word(FRAC_W));

    ch_req_t [NUM_CH-1:0] req;

    fstep_req_merge #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_merge (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid_i (cmd_valid_i),
        .cmd_ch_i    (cmd_ch_i),
        .cmd_op_i    (cmd_op_i),
        .pin_up_i    (pin_up_i),
        .pin_dn_i    (pin_dn_i),
        .req_o       (req)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        fstep_channel #(
            .WORD_W     (WORD_W),
            .MIN_WORD   (MIN_WORD),
            .MAX_WORD   (MAX_WORD),
            .RESET_WORD (RESET_WORD)
        ) u_ch (
            .clk    (clk),
            .rst    (rst),
            .req_i  (req[c]),
            .data_i (cmd_data_i),
            .wrap_i (wrap_i[c]),
            .word_o (div_word_o[c*WORD_W +: WORD_W]),
            .oor_o  (oor_o[c])
        );
    end

endmodule

// File: tb/test_fstep_ctrl.sv
`timescale 1ns/1ps
module test_fstep_ctrl;
    localparam int NCH = 4;
    localparam int WW  = 12;
    localparam int FW  = 4;
    localparam int LO  = 8 << FW;
    localparam int HI  = 2000;
    localparam int RW  = 400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_ch = '0;
    logic [1:0]        cmd_op = '0;
    logic [WW-1:0]     cmd_data = '0;
    logic              pin_up = 1'b0;
    logic              pin_dn = 1'b0;
    logic [NCH-1:0]    wrap = '0;
    logic [NCH*WW-1:0] div_word;
    logic [NCH-1:0]    oor;

    fstep_ctrl #(
        .NUM_CH(NCH), .WORD_W(WW), .FRAC_W(FW), .MAX_WORD(HI), .RESET_WORD(RW)
    ) i_fstep_ctrl (
        .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid), .cmd_ch_i(cmd_ch),
        .cmd_op_i(cmd_op), .cmd_data_i(cmd_data), .pin_up_i(pin_up),
        .pin_dn_i(pin_dn), .wrap_i(wrap), .div_word_o(div_word), .oor_o(oor)
    );

    int m_cur [NCH];
    int m_nxt [NCH];
    int m_step[NCH];
    bit m_pend[NCH];
    bit m_flag[NCH];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic idle();
        cmd_valid = 1'b0; pin_up = 1'b0; pin_dn = 1'b0; wrap = '0;
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_cur[c] = RW; m_nxt[c] = RW; m_step[c] = 1; m_pend[c] = 0; m_flag[c] = 0;
        end
    endtask

    // expected next state from the requirements, using inputs present at the edge
    task automatic model_edge();
        for (int c = 0; c < NCH; c++) begin
            bit hit, up, dn, ld, ss, applied;
            int nn, d;
            hit = cmd_valid && (int'(cmd_ch) == c);
            d   = int'(cmd_data);
            ld  = hit && cmd_op == 2'd0;
            ss  = hit && cmd_op == 2'd1;
            up  = (hit && cmd_op == 2'd2) || (c == 0 && pin_up);   // R8
            dn  = (hit && cmd_op == 2'd3) || (c == 0 && pin_dn);
            applied = 0;
            nn = m_nxt[c];
            if (ld) begin                                          // R10 load first
                if (d >= LO && d <= HI) begin nn = d; m_flag[c] = 0; applied = 1; end
                else m_flag[c] = 1;
            end else if (up && !dn) begin                          // R9 conflict skips
                if (m_nxt[c] - m_step[c] >= LO) begin nn = m_nxt[c] - m_step[c]; applied = 1; end
                else m_flag[c] = 1;
            end else if (dn && !up) begin
                if (m_nxt[c] + m_step[c] <= HI) begin nn = m_nxt[c] + m_step[c]; applied = 1; end
                else m_flag[c] = 1;
            end
            if (wrap[c] && m_pend[c]) m_cur[c] = m_nxt[c];
            m_pend[c] = (m_pend[c] && !wrap[c]) || applied;
            m_nxt[c]  = nn;
            if (ss) m_step[c] = d;
        end
    endtask

    task automatic compare(input string tag);
        for (int c = 0; c < NCH; c++) begin
            int got;
            got = int'(div_word[c*WW +: WW]);
            checks++;
            if (got != m_cur[c]) begin
                fails++;
                $display("FAIL %s ch%0d divider word: actual %0d expected %0d", tag, c, got, m_cur[c]);
            end
            checks++;
            if (oor[c] != m_flag[c]) begin
                fails++;
                $display("FAIL %s ch%0d range flag: actual %0d expected %0d", tag, c, oor[c], m_flag[c]);
            end
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic cmd(input int ch, input int op, input int data,
                       input logic [NCH-1:0] wr, input string tag);
        cmd_valid = 1'b1; cmd_ch = 2'(ch); cmd_op = 2'(op); cmd_data = WW'(data); wrap = wr;
        tick(tag);
        idle();
    endtask

    task automatic pins(input bit u, input bit d, input logic [NCH-1:0] wr, input string tag);
        pin_up = u; pin_dn = d; wrap = wr;
        tick(tag);
        idle();
    endtask

    // watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int steps[4];
        steps[0] = 1; steps[1] = 3; steps[2] = 37; steps[3] = 255;
        model_reset();
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare("R1");
        tick("R1");

        // R4: target held back until the wrap strobe
        cmd(1, 2, 0, 4'b0000, "R4");
        tick("R4");
        tick("R4");
        wrap = 4'b0010; tick("R4"); idle();
        cmd(1, 2, 0, 4'b1101, "R4");
        cmd(1, 2, 0, 4'b0000, "R4");
        wrap = 4'b0010; tick("R4"); idle();

        // R2 R3 R5 R6 R7: walk each channel to both limits with several step sizes
        for (int c = 0; c < NCH; c++) begin
            for (int s = 0; s < 4; s++) begin
                cmd(c, 1, steps[s], '1, "R2");
                cmd(c, 0, RW, '1, "R7");
                for (int i = 0; i < 3000 && !m_flag[c]; i++) begin
                    logic [NCH-1:0] wr;
                    wr = '1;
                    wr[c] = (i % 3) != 0;
                    cmd(c, 2, 0, wr, "R3/R5");
                end
                wrap = '1; tick("R5"); idle();
                cmd(c, 2, 0, '1, "R7");
                tick("R7");
                cmd(c, 0, RW, '1, "R7");
                for (int i = 0; i < 3000 && !m_flag[c]; i++) begin
                    logic [NCH-1:0] wr;
                    wr = '1;
                    wr[c] = (i % 4) != 1;
                    cmd(c, 3, 0, wr, "R3/R6");
                end
                wrap = '1; tick("R6"); idle();
            end
        end

        // R5 exact boundary on channel 2
        cmd(2, 1, 5, '1, "R5");
        cmd(2, 0, LO + 5, '1, "R5");
        cmd(2, 2, 0, '1, "R5");
        cmd(2, 2, 0, '1, "R5");
        wrap = '1; tick("R5"); idle();
        // R6 exact boundary on channel 3
        cmd(3, 1, 5, '1, "R6");
        cmd(3, 0, HI - 5, '1, "R6");
        cmd(3, 3, 0, '1, "R6");
        cmd(3, 3, 0, '1, "R6");
        wrap = '1; tick("R6"); idle();
        // R7: out-of-window loads refused, in-window load clears
        cmd(1, 0, RW, '1, "R7");
        cmd(1, 0, LO - 1, '1, "R7");
        cmd(1, 0, HI + 1, '1, "R7");
        wrap = '1; tick("R7"); idle();
        cmd(1, 0, 777, '1, "R7");
        wrap = '1; tick("R7"); idle();

        // R8: pins act on channel 0 only
        for (int c = 0; c < NCH; c++) cmd(c, 0, 1000, '1, "R8");
        for (int c = 0; c < NCH; c++) cmd(c, 1, 11, '1, "R8");
        for (int i = 0; i < 12; i++) pins(1, 0, '1, "R8");
        for (int i = 0; i < 20; i++) pins(0, 1, '1, "R8");
        wrap = '1; tick("R8"); idle();

        // R9: opposing requests on channel 0 cancel
        pins(1, 1, '1, "R9");
        pin_up = 1'b1; cmd(0, 3, 0, '1, "R9");
        pin_dn = 1'b1; cmd(0, 2, 0, '1, "R9");
        pin_up = 1'b1; cmd(1, 3, 0, '1, "R9");
        pin_up = 1'b1; cmd(0, 2, 0, '1, "R9");
        wrap = '1; tick("R9"); idle();

        // R10: load beats a pin step
        pin_up = 1'b1; cmd(0, 0, 1500, '1, "R10");
        pin_dn = 1'b1; cmd(0, 0, 300, '1, "R10");
        wrap = '1; tick("R10"); idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule